// File: doc/BRIEF.md
# Fractional-N Feedback Clock Divider

This block is the programmable counter in the feedback path of a frequency synthesizer. It runs on the oscillator clock. It counts a modulus worth of clocks, then starts the next output period. The modulus of each period is an integer base plus a small signed offset from an external modulator. An offset sequence such as 0,0,0,+1 on a base of 4 therefore gives a long-run division ratio of 4.25. Sequences 0,+1 and 0,+1,+1,+1 give 4.5 and 4.75.

The divider loads the modulus for the next period only in the last clock of the current one. It asserts a one-clock strobe when each new period begins, and the modulator uses this strobe to step to its next value. A valid flag qualifies the offset. When the flag is low, the offset counts as zero. The sum is held at two or more, so no period can be empty. The divided output is high for the first half of each period, rounded down, and low for the remaining clocks.

Top module: `fracn_clk_div`

## Requirements
- R1: While reset is low, the strobe is 0 and the divided clock is 1. The first period after reset lasts exactly the base ratio in clocks, with the offset taken as zero. The first strobe appears on the clock edge that ends that period.
- R2: The number of clocks from one strobe assertion to the next equals the modulus of that period. That modulus is base + offset, both sampled in the final clock of the preceding period.
- R3: When the valid flag is low in that final clock, the offset value has no effect, and the modulus equals the base.
- R4: A modulus below 2 is raised to 2. Examples are base 3 with offset -4, and base 0.
- R5: Changes on the offset, the valid flag or the base during any clock other than the final one of a period do not change the length of the current period or of the next one.
- R6: Within each period of modulus M, the divided clock is high for floor(M/2) clocks, starting with the strobe clock, and low for the rest.
- R7: The strobe is high for exactly one clock per period.
- R8: A new base ratio first applies to the period that starts after the next period boundary. The period in progress keeps its length.
- R9: On base 4, repeating offsets 0,0,0,+1 give 68 clocks per 16 periods. Repeating 0,+1 gives 72. Repeating 0,+1,+1,+1 gives 76.
- R10: The sum does not wrap. Base 31 with offset +3 gives a period of 34 clocks (3-bit two's-complement offset, 5-bit base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | BASE_W | Unsigned integer base ratio |
| ofs_i | input | OFS_W | Two's-complement per-period offset |
| ofs_valid_i | input | 1 | Qualifies ofs_i; low means offset zero |
| div_clk_o | output | 1 | Divided clock, high for the first half of each period |
| cyc_strobe_o | output | 1 | One-clock pulse at the start of each period; tells the modulator to advance |

## Verification
The hardest case to reach from the ports is a change on the inputs partway through a period while the final-clock value is still to come. The stimulus for this case has two steps. At the strobe clock it drives a deliberately wrong offset, with valid high. One clock later it drives the intended value. That order means the wrong value sits on the inputs early in a period, but it is gone by the sampling clock, even for a modulus of 2. The same task also changes the base at the strobe. A period that keeps its old length then shows that the new base is held back until the next boundary.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

    localparam int MOD_BITS = 16;

    typedef logic [MOD_BITS-1:0] mod_t;

    typedef struct packed {
        mod_t cnt;
        mod_t modv;
    } cnt_state_t;

    typedef struct packed {
        logic hi;
        logic stb;
    } shape_state_t;

    function automatic mod_t half_of(mod_t m);
        return m >> 1;
    endfunction

endpackage

// File: rtl/fracn_mod_calc.sv
module fracn_mod_calc
    import fracn_div_pkg::*;
#(
    parameter int BASE_W  = 5,
    parameter int OFS_W   = 3,
    parameter int MIN_MOD = 2
) (
    input  logic                    [BASE_W-1:0] base_i,
    input  logic signed             [OFS_W-1:0]  ofs_i,
    input  logic                                 use_ofs_i,
    output mod_t                                 mod_o
);
    localparam int SUM_W = MOD_BITS + 1;

    logic signed [SUM_W-1:0] base_ext;
    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        base_ext = {{(SUM_W-BASE_W){1'b0}}, base_i};
        ofs_ext  = use_ofs_i ? {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i}
                             : '0;
        sum      = base_ext + ofs_ext;
        if (sum < SUM_W'(MIN_MOD)) begin
            mod_o = mod_t'(MIN_MOD);
        end else begin
            mod_o = sum[MOD_BITS-1:0];
        end
    end

    always_comb begin
        a_floor_r4: assert (mod_o >= mod_t'(MIN_MOD) || $isunknown(base_i));
    end

endmodule

// File: rtl/fracn_cycle_counter.sv
module fracn_cycle_counter
    import fracn_div_pkg::*;
#(
    parameter int MIN_MOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  mod_t next_mod_i,
    output logic term_o,
    output mod_t cnt_d_o,
    output mod_t mod_d_o,
    output mod_t cnt_o,
    output mod_t mod_o
);
    cnt_state_t st_d, st_q;
    logic       term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == st_q.modv - mod_t'(1));
        if (!rst_n) begin
            st_d.cnt  = '0;
            st_d.modv = next_mod_i;
        end else if (term) begin
            st_d.cnt  = '0;
            st_d.modv = next_mod_i;
        end else begin
            st_d.cnt  = st_q.cnt + mod_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign term_o  = term;
    assign cnt_d_o = st_d.cnt;
    assign mod_d_o = st_d.modv;
    assign cnt_o   = st_q.cnt;
    assign mod_o   = st_q.modv;

    p_cnt_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.modv);

    p_mod_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.modv >= mod_t'(MIN_MOD));

    p_hold_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(st_q.modv));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (st_q.cnt == '0));

endmodule

// File: rtl/fracn_out_shaper.sv
module fracn_out_shaper
    import fracn_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic term_i,
    input  mod_t cnt_d_i,
    input  mod_t mod_d_i,
    output logic div_clk_o,
    output logic strobe_o
);
    shape_state_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.hi  = (cnt_d_i < half_of(mod_d_i));
        sh_d.stb = rst_n && term_i;
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign div_clk_o = sh_q.hi;
    assign strobe_o  = sh_q.stb;

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.stb |=> !sh_q.stb);

    p_high_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.stb |-> sh_q.hi);

endmodule

// File: rtl/fracn_clk_div.sv
module fracn_clk_div
    import fracn_div_pkg::*;
#(
    parameter int BASE_W  = 5,
    parameter int OFS_W   = 3,
    parameter int MIN_MOD = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BASE_W-1:0]           base_i,
    input  logic signed [OFS_W-1:0]     ofs_i,
    input  logic                        ofs_valid_i,
    output logic                        div_clk_o,
    output logic                        cyc_strobe_o
);
    mod_t next_mod;
    mod_t cnt_d, mod_d, cnt_q, mod_q;
    logic term;
    logic use_ofs;

    // Reset loads the plain base: offset forced to zero.
    assign use_ofs = rst_n && ofs_valid_i;

    fracn_mod_calc #(
        .BASE_W (BASE_W),
        .OFS_W  (OFS_W),
        .MIN_MOD(MIN_MOD)
    ) u_calc (
        .base_i   (base_i),
        .ofs_i    (ofs_i),
        .use_ofs_i(use_ofs),
        .mod_o    (next_mod)
    );

    fracn_cycle_counter #(
        .MIN_MOD(MIN_MOD)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_mod_i(next_mod),
        .term_o    (term),
        .cnt_d_o   (cnt_d),
        .mod_d_o   (mod_d),
        .cnt_o     (cnt_q),
        .mod_o     (mod_q)
    );

    fracn_out_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .term_i   (term),
        .cnt_d_i  (cnt_d),
        .mod_d_i  (mod_d),
        .div_clk_o(div_clk_o),
        .strobe_o (cyc_strobe_o)
    );

    p_strobe_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strobe_o |-> (cnt_q == '0));

    p_low_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= half_of(mod_q)) |-> !div_clk_o);

endmodule

// File: tb/fracn_clk_div_bench.sv
module fracn_clk_div_bench;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [4:0]        base_i;
    logic signed [2:0] ofs_i;
    logic              ofs_valid_i;
    logic              div_clk_o;
    logic              cyc_strobe_o;

    int checks = 0;
    int fails  = 0;
    int pend   = 0;
    int last_len = 0;

    always #4 clk = ~clk;

    fracn_clk_div u_fracn_clk_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_i      (base_i),
        .ofs_i       (ofs_i),
        .ofs_valid_i (ofs_valid_i),
        .div_clk_o   (div_clk_o),
        .cyc_strobe_o(cyc_strobe_o)
    );

    function automatic int clamp2(int x);
        return (x < 2) ? 2 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int b, input int o, input bit v);
        base_i      = 5'(b);
        ofs_i       = 3'(o);
        ofs_valid_i = v;
    endtask

    // Called at a negedge where the strobe was just seen high.
    // Drives the settings for the period after this one, measures this one.
    task automatic step(input int b, input int o, input bit v, input bit garble,
                        input string req);
        int exp_len = pend;
        int len = 1;
        int hi  = int'(div_clk_o);
        if (garble) drive((b + 7) % 32, -4, 1'b1);
        else        drive(b, o, v);
        forever begin
            @(negedge clk);
            if (garble && len == 1) drive(b, o, v);
            if (cyc_strobe_o) break;
            len++;
            hi += int'(div_clk_o);
            if (len > 100) break;
        end
        chk(len == exp_len, req, len, exp_len);
        chk(hi == exp_len / 2, "R6", hi, exp_len / 2);
        last_len = len;
        pend = clamp2(b + (v ? o : 0));
    endtask

    task automatic t_reset();
        int n = 0;
        rst_n = 1'b0;
        drive(6, 3, 1'b1);
        repeat (3) @(negedge clk);
        chk(cyc_strobe_o == 1'b0, "R1 strobe", int'(cyc_strobe_o), 0);
        chk(div_clk_o == 1'b1, "R1 divclk", int'(div_clk_o), 1);
        rst_n = 1'b1;
        drive(6, 0, 1'b0);
        forever begin
            @(negedge clk);
            n++;
            if (cyc_strobe_o || n > 100) break;
        end
        chk(n == 6, "R1 first period", n, 6);
        pend = 6;
    endtask

    task automatic t_integer();
        for (int i = 0; i < 6; i++) step(4, 0, 1'b1, 1'b0, "R2 base4");
        step(9, 0, 1'b1, 1'b0, "R8 old base kept");
        step(9, 0, 1'b1, 1'b0, "R8 new base");
        step(5, 0, 1'b1, 1'b0, "R6 odd 9");
        step(5, 0, 1'b1, 1'b0, "R6 odd 5");
    endtask

    task automatic t_pattern(input int p0, input int p1, input int p2, input int p3,
                             input int exp_total, input string req);
        int pat[4];
        int total = 0;
        pat[0] = p0; pat[1] = p1; pat[2] = p2; pat[3] = p3;
        step(4, pat[0], 1'b1, 1'b0, "R2 prime");
        for (int i = 0; i < 16; i++) begin
            step(4, pat[(i + 1) % 4], 1'b1, 1'b0, "R2 pattern");
            total += last_len;
        end
        chk(total == exp_total, req, total, exp_total);
    endtask

    task automatic t_invalid();
        step(7, 3, 1'b0, 1'b0, "R2 prime");
        step(7, -2, 1'b0, 1'b0, "R3 offset ignored +3");
        step(4, 0, 1'b1, 1'b0, "R3 offset ignored -2");
    endtask

    task automatic t_clamp();
        step(3, -4, 1'b1, 1'b0, "R2 prime");
        step(0, 0, 1'b1, 1'b0, "R4 base3 ofs-4");
        step(1, -1, 1'b1, 1'b0, "R4 base0");
        step(6, 0, 1'b1, 1'b0, "R4 base1 ofs-1");
    endtask

    task automatic t_midcycle();
        step(5, 2, 1'b1, 1'b1, "R5 prime");
        step(3, -1, 1'b1, 1'b1, "R5 garbage early");
        step(2, -3, 1'b1, 1'b1, "R5 garbage early");
        step(4, 1, 1'b1, 1'b1, "R5 garbage in min period");
        step(4, 0, 1'b1, 1'b0, "R5 settle");
    endtask

    task automatic t_upper();
        step(31, 3, 1'b1, 1'b0, "R2 prime");
        step(20, -1, 1'b1, 1'b0, "R10 base31 ofs+3");
        for (int b = 8; b <= 20; b += 4)
            step(b, 1, 1'b1, 1'b0, "R2 extended base");
        step(4, 0, 1'b1, 1'b0, "R2 extended base");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_pattern(0, 0, 0, 1, 68, "R9 avg 4.25");
        t_pattern(0, 1, 0, 1, 72, "R9 avg 4.5");
        t_pattern(0, 1, 1, 1, 76, "R9 avg 4.75");
        t_invalid();
        t_clamp();
        t_midcycle();
        t_upper();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule